// File: doc/BRIEF.md
# Masked Burst Address Counter

This block produces the address for one port of a synchronous memory. It can run through a burst without the caller driving every address. A counter register holds the current address. A mask register of the same width sits beside it. Bits set to one in the mask are free to change, and bits cleared to zero are pinned to their value. The counter can be loaded from the external address bus, advanced by one, held, or cleared. Each of these actions touches only the free bits where the requirements say so. The mask itself can be restored to all ones or loaded from the address bus.

A mode-select input decides whether the strobes act on the counter or on the mask. Either register can be copied onto a registered readback bus, so software-visible state can be returned on the address side. A master reset acts at once, without waiting for the clock, and returns both registers to their start values. No chip-enable input exists: every operation takes effect on the clock edge whenever it is requested.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `mrst` is high, without waiting for a clock edge, `cur_addr` is 0, the mask is all ones, `rdbk_data` is 0 and `rdbk_vld` is 0.
- R2: With `msel`=0 and `clr`=1, after the edge every counter bit whose mask bit is 1 is 0, and every bit whose mask bit is 0 keeps its value.
- R3: With `msel`=0, `clr`=0 and `load`=1, after the edge `cur_addr` equals `addr_in`, whatever the mask.
- R4: With `msel`=0 and only `inc` among the strobes, the bits whose mask bit is 1 are treated as one binary number, taken in order of bit position, and that number is increased by one with wrap to zero. The carry skips over bits whose mask bit is 0, and those bits do not change.
- R5: With no strobe high, or with only `rdbk` high, the counter and the mask keep their values across any number of edges.
- R6: Strobe priority is `clr` over `load` over `rdbk` over `inc`, and only the winning strobe acts in a cycle.
- R7: With `msel`=1 and `clr`=1, the mask becomes all ones after the edge and the counter is unchanged.
- R8: With `msel`=1, `clr`=0 and `load`=1, the mask becomes `addr_in` after the edge and the counter is unchanged.
- R9: A cycle whose winning strobe is `rdbk` puts, after the edge, the counter (`msel`=0) or the mask (`msel`=1) on `rdbk_data`, with `rdbk_vld`=1 for that one cycle. In other cycles `rdbk_vld` is 0 and `rdbk_data` holds its last value.
- R10: With `msel`=1 and only `inc` high (the reserved code), neither the counter nor the mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| mrst | input | 1 | Master reset, active high, asynchronous |
| addr_in | input | 17 | External address, the source for counter and mask loads |
| msel | input | 1 | 0: strobes act on the counter, 1: strobes act on the mask |
| clr | input | 1 | Clear strobe (counter reset or mask reset) |
| load | input | 1 | Load strobe |
| rdbk | input | 1 | Readback strobe |
| inc | input | 1 | Increment strobe (counter only) |
| cur_addr | output | 17 | Current counter value |
| rdbk_data | output | 17 | Registered readback of the counter or the mask |
| rdbk_vld | output | 1 | High for one cycle after a readback |

## Verification
The hardest case to reach is an increment whose carry must skip a run of pinned bits. That needs a sparse mask together with a counter whose free bits are nearly all ones, and uniform random stimulus seldom lines both up. The stimulus therefore loads such masks and counter values directly before issuing increments. It also mixes in random strobe combinations, so that the priority rules and the effect of each mode on the other register are covered. The mask state is read out through the mask readback path, because no port shows it directly.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_CLR  = 3'd1,
    OP_LOAD = 3'd2,
    OP_RDBK = 3'd3,
    OP_INC  = 3'd4
  } op_e;
endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic msel,
  input  logic clr,
  input  logic load,
  input  logic rdbk,
  input  logic inc,
  output op_e  cnt_op,
  output op_e  msk_op,
  output logic rd_sel_mask
);
  op_e win;

  // fixed priority: clear, load, readback, increment
  always_comb begin
    if (clr)       win = OP_CLR;
    else if (load) win = OP_LOAD;
    else if (rdbk) win = OP_RDBK;
    else if (inc)  win = OP_INC;
    else           win = OP_HOLD;
  end

  always_comb begin
    cnt_op = OP_HOLD;
    msk_op = OP_HOLD;
    if (!msel) begin
      cnt_op = win;
    end else if (win != OP_INC) begin
      // increment in mask mode is the reserved code: no-op
      msk_op = win;
    end
  end

  assign rd_sel_mask = msel;
endmodule

// File: rtl/bac_mask.sv
module bac_mask
  import bac_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         mrst,
  input  op_e          op,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] mask_q
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst) begin
      mask_q <= ALL_ONES;
    end else begin
      unique case (op)
        OP_CLR:  mask_q <= ALL_ONES;
        OP_LOAD: mask_q <= addr_in;
        default: mask_q <= mask_q;
      endcase
    end
  end

  AST_MASK_RST: assert property (@(posedge clk) disable iff (mrst)
    (op == OP_CLR) |=> (mask_q == ALL_ONES)); // R7
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (mrst)
    (op == OP_LOAD) |=> (mask_q == $past(addr_in))); // R8
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (mrst)
    (op == OP_HOLD || op == OP_RDBK) |=> $stable(mask_q)); // R10
endmodule

// File: rtl/bac_counter.sv
module bac_counter
  import bac_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         mrst,
  input  op_e          op,
  input  logic [W-1:0] addr_in,
  input  logic [W-1:0] mask,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] bridged;
  logic [W-1:0] stepped;
  logic [W-1:0] inc_val;

  // Force pinned bits to one so the carry passes through them,
  // then restore the pinned bits from the current value.
  assign bridged = cnt_q | ~mask;
  assign stepped = bridged + {{(W-1){1'b0}}, 1'b1};
  assign inc_val = (stepped & mask) | (cnt_q & ~mask);

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst) begin
      cnt_q <= '0;
    end else begin
      unique case (op)
        OP_CLR:  cnt_q <= cnt_q & ~mask;
        OP_LOAD: cnt_q <= addr_in;
        OP_INC:  cnt_q <= inc_val;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_CLR_FREE_ZERO: assert property (@(posedge clk) disable iff (mrst)
    (op == OP_CLR) |=> ((cnt_q & $past(mask)) == '0)); // R2
  AST_CLR_PINNED_KEEP: assert property (@(posedge clk) disable iff (mrst)
    (op == OP_CLR) |=> (((cnt_q ^ $past(cnt_q)) & ~$past(mask)) == '0)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (mrst)
    (op == OP_LOAD) |=> (cnt_q == $past(addr_in))); // R3
  AST_INC_PINNED: assert property (@(posedge clk) disable iff (mrst)
    (op == OP_INC) |=> (((cnt_q ^ $past(cnt_q)) & ~$past(mask)) == '0)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (mrst)
    (op == OP_HOLD || op == OP_RDBK) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import bac_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         mrst,
  input  logic [W-1:0] addr_in,
  input  logic         msel,
  input  logic         clr,
  input  logic         load,
  input  logic         rdbk,
  input  logic         inc,
  output logic [W-1:0] cur_addr,
  output logic [W-1:0] rdbk_data,
  output logic         rdbk_vld
);
  op_e          cnt_op;
  op_e          msk_op;
  logic         rd_sel_mask;
  logic [W-1:0] mask_q;
  logic [W-1:0] cnt_q;

  bac_decode u_dec (
    .msel        (msel),
    .clr         (clr),
    .load        (load),
    .rdbk        (rdbk),
    .inc         (inc),
    .cnt_op      (cnt_op),
    .msk_op      (msk_op),
    .rd_sel_mask (rd_sel_mask)
  );

  bac_mask #(.W(W)) u_mask (
    .clk     (clk),
    .mrst    (mrst),
    .op      (msk_op),
    .addr_in (addr_in),
    .mask_q  (mask_q)
  );

  bac_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .mrst    (mrst),
    .op      (cnt_op),
    .addr_in (addr_in),
    .mask    (mask_q),
    .cnt_q   (cnt_q)
  );

  logic rd_req;
  assign rd_req = (cnt_op == OP_RDBK) || (msk_op == OP_RDBK);

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst) begin
      rdbk_data <= '0;
      rdbk_vld  <= 1'b0;
    end else begin
      rdbk_vld <= rd_req;
      if (rd_req) rdbk_data <= rd_sel_mask ? mask_q : cnt_q;
    end
  end

  assign cur_addr = cnt_q;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (mrst)
    $onehot0({cnt_op != OP_HOLD, msk_op != OP_HOLD})); // R6
  AST_RDBK_PULSE: assert property (@(posedge clk) disable iff (mrst)
    !rdbk |=> !rdbk_vld); // R9
  AST_RDBK_KEEP: assert property (@(posedge clk) disable iff (mrst)
    !rd_req |=> $stable(rdbk_data)); // R9
  AST_RESET_VALUES: assert property (@(posedge clk)
    mrst |-> (cur_addr == '0 && !rdbk_vld && rdbk_data == '0)); // R1
endmodule

// File: tb/sim_burst_addr_ctr.sv
module sim_burst_addr_ctr;
  localparam int W = 17;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         mrst = 1'b1;
  logic [W-1:0] addr_in = '0;
  logic         msel = 1'b0, clr = 1'b0, load = 1'b0, rdbk = 1'b0, inc = 1'b0;
  logic [W-1:0] cur_addr, rdbk_data;
  logic         rdbk_vld;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_cnt = '0, m_mask = ONES, m_rd = '0;
  logic         m_vld = 1'b0;

  always #10 clk = ~clk;

  burst_addr_ctr #(.W(W)) u0 (
    .clk(clk), .mrst(mrst), .addr_in(addr_in), .msel(msel), .clr(clr),
    .load(load), .rdbk(rdbk), .inc(inc), .cur_addr(cur_addr),
    .rdbk_data(rdbk_data), .rdbk_vld(rdbk_vld)
  );

  // bitwise model of the skipping increment
  function automatic logic [W-1:0] f_inc(logic [W-1:0] c, logic [W-1:0] m);
    logic [W-1:0] r = c;
    logic carry = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (m[i] && carry) begin
        r[i]  = ~c[i];
        carry = c[i];
      end
    end
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [W-1:0] c = m_cnt, m = m_mask;
    m_vld = 1'b0;
    if (!msel) begin
      if (clr)       m_cnt = c & ~m;
      else if (load) m_cnt = addr_in;
      else if (rdbk) begin m_rd = c; m_vld = 1'b1; end
      else if (inc)  m_cnt = f_inc(c, m);
    end else begin
      if (clr)       m_mask = ONES;
      else if (load) m_mask = addr_in;
      else if (rdbk) begin m_rd = m; m_vld = 1'b1; end
    end
  endtask

  // called at a negedge; drives, clocks, then compares at the next negedge
  task automatic step(string req, logic s, logic c, logic l, logic r,
                      logic i, logic [W-1:0] a);
    msel = s; clr = c; load = l; rdbk = r; inc = i; addr_in = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(req, cur_addr, m_cnt);
    chk(req, {{(W-1){1'b0}}, rdbk_vld}, {{(W-1){1'b0}}, m_vld});
    chk(req, rdbk_data, m_rd);
  endtask

  task automatic read_mask(string req);
    step(req, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    chk(req, rdbk_data, m_mask);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #3;
    // R1: values while reset is high, before any edge
    chk("R1", cur_addr, '0);
    chk("R1", rdbk_data, '0);
    repeat (2) @(negedge clk);
    mrst = 1'b0;
    read_mask("R1");

    // R3 load, R9 counter readback
    step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 17'h1ABCD);
    step("R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
    chk("R9", rdbk_data, 17'h1ABCD);
    // R5 hold over several cycles
    repeat (4) step("R5", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17'h00055);
    chk("R5", cur_addr, 17'h1ABCD);
    // R4 wrap with full mask
    step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ONES);
    step("R4", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    chk("R4", cur_addr, '0);
    // R8 sparse mask, carry skips pinned bits
    step("R8", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 17'h10101);
    read_mask("R8");
    chk("R8", rdbk_data, 17'h10101);
    step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 17'h0EEF1);
    step("R4", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    chk("R4", cur_addr, 17'h0EFF0);
    repeat (6) step("R4", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    // R2 clear only free bits
    step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ONES);
    step("R2", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk("R2", cur_addr, 17'h0FEFE);
    // R6 priority: clear beats load, load beats readback and inc
    step("R6", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 17'h00AAA);
    step("R6", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 17'h00AAA);
    chk("R6", cur_addr, 17'h00AAA);
    // R10 reserved code, R7 mask reset
    step("R10", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 17'h1FFFF);
    chk("R10", cur_addr, 17'h00AAA);
    read_mask("R10");
    step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0);
    chk("R7", cur_addr, 17'h00AAA);
    read_mask("R7");
    chk("R7", rdbk_data, ONES);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] s = 4'($urandom);
      logic [W-1:0] a = W'($urandom);
      if (n % 97 == 0) a = W'($urandom) | W'($urandom) | W'($urandom);
      step("R6", ($urandom % 4) == 0, s[0] & s[1], s[2] & ~s[0],
           ($urandom % 5) == 0, s[3] | s[1], a);
      if (n % 500 == 250) read_mask("R8");
    end

    // R1 asynchronous reset in mid-cycle
    @(negedge clk);
    #5 mrst = 1'b1;
    #1;
    chk("R1", cur_addr, '0);
    chk("R1", {{(W-1){1'b0}}, rdbk_vld}, '0);
    m_cnt = '0; m_mask = ONES; m_rd = '0; m_vld = 1'b0;
    @(negedge clk);
    mrst = 1'b0;
    read_mask("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule